// File: doc/BRIEF.md
# PCI configuration header register file

This block holds the Type-0 configuration header of one PCI device function. A host reaches it through a plain register port. Each access carries a byte offset, an access size of 1, 2 or 4 bytes, a write enable and write data. Read data and an error flag come back one clock later. The header holds fixed identification and class fields, a writable command word, cache line size, latency timer and interrupt line, fixed status, interrupt pin and bus timing hints, six base address registers (BARs) and the expansion ROM base.

Each BAR has a window size fixed at elaboration. Software writes all ones to a BAR to learn its size, then writes the base it assigns. The read-only type bits at the bottom of the BAR never change. The BAR's kind comes from bit 0 of its reset value: I/O BARs protect two low bits and memory BARs protect four. Every BAR drives its programmed base and an enable flag, so that a neighbouring address decoder can claim cycles. Writes go through a filter that depends on both size and offset. Writes to registers that are read-only by nature are dropped quietly. Writes that no configuration cycle should make are rejected with the error flag.

Top module: `cfg_header_regs`

## Requirements
- R1: After synchronous reset, every header byte reads its parameter default, every BAR reads its reset value, all enable flags are low, and the unimplemented header bytes read 0.
- R2: An access whose size code is not 1, 2 or 4 raises `acc_err` in the following cycle, returns zero read data and changes no register.
- R3: An access at offset 0x40 or above (the device-specific region) raises `acc_err` in the following cycle and changes no register.
- R4: A legal read returns, one cycle later, the header bytes at offset, offset+1, ... in little-endian order in the low `size` bytes of `acc_rdata`. Unused upper bytes and bytes past offset 0x3F read 0. A read changes nothing.
- R5: A 1-byte write is stored at offset 0x3C (interrupt line), 0x0C (cache line size) or 0x0D (latency timer).
- R6: A 1-byte write to 0x3D, 0x3E, 0x3F, 0x0B or 0x08 is dropped without error. A 1-byte write to any other offset is dropped and raises `acc_err`.
- R7: A 2-byte or 4-byte write at offset 0x04 loads the 16-bit command word from data bits [15:0], and status stays unchanged. Any other 2-byte write raises `acc_err`. A 4-byte write to an offset that is not a BAR, the ROM base (0x30) or 0x04 is dropped without error.
- R8: A 4-byte write of 0xFFFFFFFF to BAR n (offset 0x10+4n) makes it read ~(SIZE_n−1) in its address bits, with its type bits unchanged. A size of 0 gives zero address bits.
- R9: Any other 4-byte write to a BAR stores the data in the address bits only. The type bits are [1:0] when bit 0 of the reset value is 1 (I/O) and [3:0] otherwise (memory), and they keep their reset value.
- R10: A 4-byte write of 0xFFFFFFFE to offset 0x30 makes the ROM base read 0xFFFFFFFF. Any other 4-byte write there is stored as written.
- R11: `bar_base` slice n equals BAR n with its type bits cleared. `bar_valid[n]` goes high after a non-sizing write whose address bits are non-zero, goes low after one whose address bits are zero, and holds through sizing writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_en | input | 1 | Access request this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_off | input | 8 | Byte offset into the header |
| acc_size | input | 3 | Access size in bytes (1, 2 or 4 are legal) |
| acc_wdata | input | 32 | Write data, little-endian |
| acc_rdata | output | 32 | Read data, valid the cycle after a read |
| acc_err | output | 1 | One-cycle pulse after a rejected access |
| bar_base | output | NUM_BARS*32 | Programmed base of each BAR, type bits cleared |
| bar_valid | output | NUM_BARS | Each BAR holds a non-zero programmed base |

## Verification
The assertions assume that reset is held for at least two clock edges from time zero. They also assume that the requester presents at most one access per cycle and keeps `acc_en` low when idle, since any cycle with `acc_en` high counts as an access. The stimulus drives every access for exactly one cycle from the falling edge, with idle cycles in between, and asserts reset only from the falling edge. Each access is checked against a byte-array model in the bench. The stimulus covers legal sizes at legal and illegal offsets, illegal size codes, sizing and normal writes on I/O BARs, memory BARs and an unimplemented BAR, and a reset in the middle of the run.

// File: rtl/cfg_hdr_pkg.sv
// Package: shared offsets, widths and write-strobe type for the
// configuration header register file.
// Assumes: a Type-0 header of 64 bytes; offsets below are decoded by
// software, so their values are fixed.
package cfg_hdr_pkg;

    localparam int HDR_BYTES    = 64;
    localparam int OFF_W        = 8;
    localparam int WORD_W       = 32;

    localparam int OFF_COMMAND  = 'h04;
    localparam int OFF_STATUS   = 'h06;
    localparam int OFF_REVISION = 'h08;
    localparam int OFF_CLASS_HI = 'h0B;
    localparam int OFF_CLS      = 'h0C;
    localparam int OFF_LATENCY  = 'h0D;
    localparam int OFF_HDRTYPE  = 'h0E;
    localparam int OFF_BAR0     = 'h10;
    localparam int OFF_SUBSYS   = 'h2C;
    localparam int OFF_ROM      = 'h30;
    localparam int OFF_INTLINE  = 'h3C;
    localparam int OFF_INTPIN   = 'h3D;
    localparam int OFF_MINGNT   = 'h3E;
    localparam int OFF_MAXLAT   = 'h3F;
    localparam int OFF_DEVSPEC  = 'h40;

    localparam logic [WORD_W-1:0] ROM_PROBE = 32'hFFFF_FFFE;

    // Write strobes for the scalar header registers plus the error flag.
    typedef struct packed {
        logic err;
        logic wr_intline;
        logic wr_cls;
        logic wr_lat;
        logic wr_cmd;
        logic wr_rom;
    } wr_ctl_t;

    // Read-only low-bit mask of a BAR, chosen by bit 0 of its reset value.
    function automatic logic [WORD_W-1:0] bar_ro_mask(input logic [WORD_W-1:0] init);
        return init[0] ? 32'h0000_0003 : 32'h0000_000F;
    endfunction

endpackage

// File: rtl/cfg_access_decode.sv
// Module: cfg_access_decode
// Classifies one register-port access by size and offset into write
// strobes, a read-accept flag or an error.
// Assumes: at most one access per cycle; purely combinational.
module cfg_access_decode
    import cfg_hdr_pkg::*;
#(
    parameter int NUM_BARS = 6
) (
    input  logic                acc_en,
    input  logic                acc_wr,
    input  logic [OFF_W-1:0]    acc_off,
    input  logic [2:0]          acc_size,
    output wr_ctl_t             ctl,
    output logic [NUM_BARS-1:0] bar_wr,
    output logic                rd_ok
);

    logic size_ok;
    logic range_ok;

    // Legal access shape: size 1, 2 or 4, offset inside the standard header.
    always_comb begin
        size_ok  = (acc_size == 3'd1) || (acc_size == 3'd2) || (acc_size == 3'd4);
        range_ok = (int'(acc_off) < OFF_DEVSPEC);
    end

    // Size- and offset-dependent write filter.
    always_comb begin
        ctl    = '0;
        bar_wr = '0;
        rd_ok  = 1'b0;
        if (acc_en) begin
            if (!(size_ok && range_ok)) begin
                ctl.err = 1'b1;
            end else if (!acc_wr) begin
                rd_ok = 1'b1;
            end else begin
                case (acc_size)
                    3'd1: begin
                        case (int'(acc_off))
                            OFF_INTLINE: ctl.wr_intline = 1'b1;
                            OFF_CLS:     ctl.wr_cls     = 1'b1;
                            OFF_LATENCY: ctl.wr_lat     = 1'b1;
                            OFF_INTPIN, OFF_MINGNT, OFF_MAXLAT,
                            OFF_CLASS_HI, OFF_REVISION: ;
                            default:     ctl.err        = 1'b1;
                        endcase
                    end
                    3'd2: begin
                        if (int'(acc_off) == OFF_COMMAND) ctl.wr_cmd = 1'b1;
                        else                              ctl.err    = 1'b1;
                    end
                    default: begin
                        if (int'(acc_off) == OFF_COMMAND) ctl.wr_cmd = 1'b1;
                        if (int'(acc_off) == OFF_ROM)     ctl.wr_rom = 1'b1;
                        for (int i = 0; i < NUM_BARS; i++) begin
                            if (int'(acc_off) == OFF_BAR0 + 4 * i) bar_wr[i] = 1'b1;
                        end
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/cfg_bar_slot.sv
// Module: cfg_bar_slot
// One base address register with size probing, read-only type bits and
// a decode-enable flag.
// Assumes: SIZE is zero (unimplemented) or a power of two not smaller
// than the read-only low field.
module cfg_bar_slot
    import cfg_hdr_pkg::*;
#(
    parameter logic [31:0] INIT = 32'h0,
    parameter logic [31:0] SIZE = 32'h1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    output logic [31:0] bar_q,
    output logic [31:0] base,
    output logic        valid
);

    localparam logic [31:0] RO_MASK  = bar_ro_mask(INIT);
    localparam logic [31:0] SIZE_VAL = ~(SIZE - 32'd1) & ~RO_MASK;

    logic probe;

    // An all-ones write is a size probe, not an address.
    always_comb probe = (wdata == 32'hFFFF_FFFF);

    // BAR storage: probe loads the size mask, otherwise the address bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bar_q <= INIT;
            valid <= 1'b0;
        end else if (wr_en) begin
            if (probe) begin
                bar_q <= SIZE_VAL | (bar_q & RO_MASK);
            end else begin
                bar_q <= (wdata & ~RO_MASK) | (bar_q & RO_MASK);
                valid <= |(wdata & ~RO_MASK);
            end
        end
    end

    // Decoder-facing base with type bits stripped.
    always_comb base = bar_q & ~RO_MASK;

    AST_TYPE_BITS_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(bar_q & RO_MASK));                                           // R9
    AST_PROBE_READS_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && probe |=> ((bar_q & ~RO_MASK) == SIZE_VAL));                // R8
    AST_VALID_FOLLOWS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !probe |=> (valid == (base != 32'h0)));                     // R11

endmodule

// File: rtl/cfg_read_mux.sv
// Module: cfg_read_mux
// Gathers up to four header bytes little-endian from the byte image.
// Assumes: size already checked; bytes past the header end read zero.
module cfg_read_mux
    import cfg_hdr_pkg::*;
#(
    parameter int NBYTES = HDR_BYTES
) (
    input  logic [NBYTES*8-1:0] hdr_flat,
    input  logic [OFF_W-1:0]    off,
    input  logic [2:0]          size,
    output logic [31:0]         data
);

    // Byte lane k carries header byte off+k when k < size.
    always_comb begin
        data = '0;
        for (int k = 0; k < 4; k++) begin
            if ((k < int'(size)) && (int'(off) + k < NBYTES)) begin
                data[8*k +: 8] = hdr_flat[(int'(off) + k) * 8 +: 8];
            end
        end
    end

endmodule

// File: rtl/cfg_header_regs.sv
// Module: cfg_header_regs (top)
// Type-0 configuration header of one function: fixed identity fields,
// writable command / cache line / latency / interrupt line, BARs with
// size probing, and the expansion ROM base. Responses are registered.
// Assumes: NUM_BARS <= 6 (BARs occupy offsets 0x10..0x27).
module cfg_header_regs
    import cfg_hdr_pkg::*;
#(
    parameter int                         NUM_BARS      = 6,
    parameter logic [15:0]                VENDOR_ID     = 16'hFFFF,
    parameter logic [15:0]                DEVICE_ID     = 16'h0000,
    parameter logic [7:0]                 REVISION      = 8'h00,
    parameter logic [23:0]                CLASS_CODE    = 24'h000000,
    parameter logic [7:0]                 HEADER_TYPE   = 8'h00,
    parameter logic [15:0]                STATUS_INIT   = 16'h0000,
    parameter logic [15:0]                CMD_INIT      = 16'h0000,
    parameter logic [7:0]                 CLS_INIT      = 8'h00,
    parameter logic [7:0]                 LAT_INIT      = 8'h00,
    parameter logic [15:0]                SUBSYS_VENDOR = 16'h0000,
    parameter logic [15:0]                SUBSYS_ID     = 16'h0000,
    parameter logic [31:0]                ROM_INIT      = 32'h0,
    parameter logic [7:0]                 INT_LINE_INIT = 8'h00,
    parameter logic [7:0]                 INT_PIN       = 8'h01,
    parameter logic [7:0]                 MIN_GNT       = 8'h00,
    parameter logic [7:0]                 MAX_LAT       = 8'h00,
    parameter logic [NUM_BARS-1:0][31:0]  BAR_INIT      = '0,
    parameter logic [NUM_BARS-1:0][31:0]  BAR_SIZE      = {NUM_BARS{32'h0000_1000}}
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     acc_en,
    input  logic                     acc_wr,
    input  logic [7:0]               acc_off,
    input  logic [2:0]               acc_size,
    input  logic [31:0]              acc_wdata,
    output logic [31:0]              acc_rdata,
    output logic                     acc_err,
    output logic [NUM_BARS*32-1:0]   bar_base,
    output logic [NUM_BARS-1:0]      bar_valid
);

    wr_ctl_t                         ctl;
    logic [NUM_BARS-1:0]             bar_wr;
    logic                            rd_ok;
    logic [NUM_BARS-1:0][31:0]       bar_q;
    logic [15:0]                     cmd_q;
    logic [7:0]                      cls_q;
    logic [7:0]                      lat_q;
    logic [7:0]                      intline_q;
    logic [31:0]                     rom_q;
    logic [HDR_BYTES-1:0][7:0]       hdr;
    logic [31:0]                     rd_word;

    cfg_access_decode #(.NUM_BARS(NUM_BARS)) u_dec (
        .acc_en   (acc_en),
        .acc_wr   (acc_wr),
        .acc_off  (acc_off),
        .acc_size (acc_size),
        .ctl      (ctl),
        .bar_wr   (bar_wr),
        .rd_ok    (rd_ok)
    );

    for (genvar g = 0; g < NUM_BARS; g++) begin : g_bar
        cfg_bar_slot #(.INIT(BAR_INIT[g]), .SIZE(BAR_SIZE[g])) u_bar (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (bar_wr[g]),
            .wdata (acc_wdata),
            .bar_q (bar_q[g]),
            .base  (bar_base[g*32 +: 32]),
            .valid (bar_valid[g])
        );
    end

    // Writable scalar header registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q     <= CMD_INIT;
            cls_q     <= CLS_INIT;
            lat_q     <= LAT_INIT;
            intline_q <= INT_LINE_INIT;
            rom_q     <= ROM_INIT;
        end else begin
            if (ctl.wr_intline) intline_q <= acc_wdata[7:0];
            if (ctl.wr_cls)     cls_q     <= acc_wdata[7:0];
            if (ctl.wr_lat)     lat_q     <= acc_wdata[7:0];
            if (ctl.wr_cmd)     cmd_q     <= acc_wdata[15:0];
            if (ctl.wr_rom)     rom_q     <= (acc_wdata == ROM_PROBE) ? 32'hFFFF_FFFF : acc_wdata;
        end
    end

    // Byte image of the header as software sees it.
    always_comb begin
        hdr                    = '0;
        hdr[0]                 = VENDOR_ID[7:0];
        hdr[1]                 = VENDOR_ID[15:8];
        hdr[2]                 = DEVICE_ID[7:0];
        hdr[3]                 = DEVICE_ID[15:8];
        hdr[OFF_COMMAND]       = cmd_q[7:0];
        hdr[OFF_COMMAND + 1]   = cmd_q[15:8];
        hdr[OFF_STATUS]        = STATUS_INIT[7:0];
        hdr[OFF_STATUS + 1]    = STATUS_INIT[15:8];
        hdr[OFF_REVISION]      = REVISION;
        hdr[OFF_REVISION + 1]  = CLASS_CODE[7:0];
        hdr[OFF_REVISION + 2]  = CLASS_CODE[15:8];
        hdr[OFF_CLASS_HI]      = CLASS_CODE[23:16];
        hdr[OFF_CLS]           = cls_q;
        hdr[OFF_LATENCY]       = lat_q;
        hdr[OFF_HDRTYPE]       = HEADER_TYPE;
        for (int i = 0; i < NUM_BARS; i++) begin
            for (int b = 0; b < 4; b++) begin
                hdr[OFF_BAR0 + 4 * i + b] = bar_q[i][8*b +: 8];
            end
        end
        hdr[OFF_SUBSYS]        = SUBSYS_VENDOR[7:0];
        hdr[OFF_SUBSYS + 1]    = SUBSYS_VENDOR[15:8];
        hdr[OFF_SUBSYS + 2]    = SUBSYS_ID[7:0];
        hdr[OFF_SUBSYS + 3]    = SUBSYS_ID[15:8];
        for (int b = 0; b < 4; b++) begin
            hdr[OFF_ROM + b]   = rom_q[8*b +: 8];
        end
        hdr[OFF_INTLINE]       = intline_q;
        hdr[OFF_INTPIN]        = INT_PIN;
        hdr[OFF_MINGNT]        = MIN_GNT;
        hdr[OFF_MAXLAT]        = MAX_LAT;
    end

    cfg_read_mux #(.NBYTES(HDR_BYTES)) u_rd (
        .hdr_flat (hdr),
        .off      (acc_off),
        .size     (acc_size),
        .data     (rd_word)
    );

    // Registered response: read data and error pulse one cycle after access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_rdata <= '0;
            acc_err   <= 1'b0;
        end else begin
            acc_rdata <= rd_ok ? rd_word : '0;
            acc_err   <= ctl.err;
        end
    end

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctl.err, ctl.wr_intline, ctl.wr_cls, ctl.wr_lat, ctl.wr_cmd, ctl.wr_rom, bar_wr})); // R6
    AST_DEVSPEC_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en && (acc_off >= 8'h40) |=> acc_err);                                               // R3
    AST_ERR_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> ($stable(cmd_q) && $stable(rom_q) && $stable(intline_q)
                     && $stable(cls_q) && $stable(lat_q) && $stable(bar_q)));                    // R2
    AST_READ_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en && !acc_wr |=> ($stable(cmd_q) && $stable(rom_q) && $stable(intline_q)
                               && $stable(bar_q) && $stable(bar_valid)));                        // R4

endmodule

// File: tb/cfg_header_regs_tb.sv
`timescale 1ns/1ps
module cfg_header_regs_tb_top;

    localparam int NB = 6;
    localparam logic [15:0] P_VID  = 16'h5A3C;
    localparam logic [15:0] P_DID  = 16'hC0DE;
    localparam logic [7:0]  P_REV  = 8'h03;
    localparam logic [23:0] P_CLS3 = 24'h028001;
    localparam logic [7:0]  P_HT   = 8'h00;
    localparam logic [15:0] P_STAT = 16'h0290;
    localparam logic [15:0] P_CMD  = 16'h0000;
    localparam logic [7:0]  P_CLS  = 8'h08;
    localparam logic [7:0]  P_LAT  = 8'h40;
    localparam logic [15:0] P_SSV  = 16'h5A3C;
    localparam logic [15:0] P_SSID = 16'h0011;
    localparam logic [31:0] P_ROM  = 32'h0;
    localparam logic [7:0]  P_INTL = 8'h0B;
    localparam logic [7:0]  P_PIN  = 8'h01;
    localparam logic [7:0]  P_MING = 8'h08;
    localparam logic [7:0]  P_MAXL = 8'h20;
    localparam logic [NB-1:0][31:0] P_BINIT = {32'h0, 32'h0, 32'h8, 32'h0, 32'h1, 32'h0};
    localparam logic [NB-1:0][31:0] P_BSIZE = {32'h0, 32'h40, 32'h10000, 32'h800, 32'h100, 32'h1000};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_en = 1'b0;
    logic acc_wr = 1'b0;
    logic [7:0] acc_off = '0;
    logic [2:0] acc_size = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic acc_err;
    logic [NB*32-1:0] bar_base;
    logic [NB-1:0] bar_valid;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [7:0]  m_hdr [64];
    logic [31:0] m_bar [NB];
    logic        m_valid [NB];

    always #4 clk = ~clk;

    cfg_header_regs #(
        .NUM_BARS(NB), .VENDOR_ID(P_VID), .DEVICE_ID(P_DID), .REVISION(P_REV),
        .CLASS_CODE(P_CLS3), .HEADER_TYPE(P_HT), .STATUS_INIT(P_STAT), .CMD_INIT(P_CMD),
        .CLS_INIT(P_CLS), .LAT_INIT(P_LAT), .SUBSYS_VENDOR(P_SSV), .SUBSYS_ID(P_SSID),
        .ROM_INIT(P_ROM), .INT_LINE_INIT(P_INTL), .INT_PIN(P_PIN), .MIN_GNT(P_MING),
        .MAX_LAT(P_MAXL), .BAR_INIT(P_BINIT), .BAR_SIZE(P_BSIZE)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr), .acc_off(acc_off),
        .acc_size(acc_size), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .acc_err(acc_err),
        .bar_base(bar_base), .bar_valid(bar_valid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ro_mask(input int i);
        return P_BINIT[i][0] ? 32'h3 : 32'hF;
    endfunction

    task automatic put_word(input int o, input logic [31:0] v, input int n);
        for (int k = 0; k < n; k++) m_hdr[o + k] = v[8*k +: 8];
    endtask

    task automatic model_reset();
        for (int k = 0; k < 64; k++) m_hdr[k] = 8'h00;
        put_word('h00, {16'h0, P_VID}, 2);
        put_word('h02, {16'h0, P_DID}, 2);
        put_word('h04, {16'h0, P_CMD}, 2);
        put_word('h06, {16'h0, P_STAT}, 2);
        put_word('h08, {P_CLS3, P_REV}, 4);
        m_hdr['h0C] = P_CLS;
        m_hdr['h0D] = P_LAT;
        m_hdr['h0E] = P_HT;
        put_word('h2C, {P_SSID, P_SSV}, 4);
        put_word('h30, P_ROM, 4);
        put_word('h3C, {P_MAXL, P_MING, P_PIN, P_INTL}, 4);
        for (int i = 0; i < NB; i++) begin
            m_bar[i]   = P_BINIT[i];
            m_valid[i] = 1'b0;
            put_word('h10 + 4 * i, m_bar[i], 4);
        end
    endtask

    // One access: drive on the falling edge, model it, check after the next rising edge.
    task automatic access(input bit w, input logic [7:0] o, input logic [2:0] s,
                          input logic [31:0] d, input string req);
        logic        e_err;
        logic [31:0] e_rd;
        int          oi;
        logic [31:0] mk;
        logic [31:0] nv;
        int          bi;
        oi    = int'(o);
        e_err = 1'b0;
        e_rd  = '0;
        @(negedge clk);
        acc_en = 1'b1; acc_wr = w; acc_off = o; acc_size = s; acc_wdata = d;
        if (!(s == 3'd1 || s == 3'd2 || s == 3'd4) || oi >= 64) begin
            e_err = 1'b1;
        end else if (!w) begin
            for (int k = 0; k < int'(s); k++) if (oi + k < 64) e_rd[8*k +: 8] = m_hdr[oi + k];
        end else if (s == 3'd1) begin
            if (oi == 'h3C || oi == 'h0C || oi == 'h0D) m_hdr[oi] = d[7:0];
            else if (!(oi == 'h3D || oi == 'h3E || oi == 'h3F || oi == 'h0B || oi == 'h08)) e_err = 1'b1;
        end else if (s == 3'd2) begin
            if (oi == 'h04) put_word('h04, d, 2);
            else e_err = 1'b1;
        end else begin
            if (oi == 'h04) put_word('h04, d, 2);
            else if (oi == 'h30) put_word('h30, (d == 32'hFFFF_FFFE) ? 32'hFFFF_FFFF : d, 4);
            else if (oi >= 'h10 && oi < 'h10 + 4 * NB && (oi % 4) == 0) begin
                bi = (oi - 'h10) / 4;
                mk = ro_mask(bi);
                if (d == 32'hFFFF_FFFF) nv = (~(P_BSIZE[bi] - 32'd1) & ~mk) | (m_bar[bi] & mk);
                else begin
                    nv = (d & ~mk) | (m_bar[bi] & mk);
                    m_valid[bi] = ((d & ~mk) != 32'h0);
                end
                m_bar[bi] = nv;
                put_word(oi, nv, 4);
            end
        end
        @(negedge clk);
        acc_en = 1'b0;
        check({req, " err"}, {31'h0, acc_err}, {31'h0, e_err});
        check({req, " rdata"}, acc_rdata, e_rd);
        for (int i = 0; i < NB; i++) begin
            check("R11 bar_base", bar_base[i*32 +: 32], m_bar[i] & ~ro_mask(i));
            check("R11 bar_valid", {31'h0, bar_valid[i]}, {31'h0, m_valid[i]});
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic read_all(input string req);
        for (int a = 0; a < 64; a += 4) access(1'b0, 8'(a), 3'd4, 32'h0, req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        read_all("R1 reset image");
        // R4 narrow and edge reads
        access(1'b0, 8'h02, 3'd1, 0, "R4 byte read");
        access(1'b0, 8'h0A, 3'd2, 0, "R4 half read");
        access(1'b0, 8'h3E, 3'd4, 0, "R4 read past end");
        access(1'b0, 8'h07, 3'd2, 0, "R4 unaligned read");
        // R2 illegal size codes
        access(1'b0, 8'h00, 3'd3, 0, "R2 size3 read");
        access(1'b1, 8'h3C, 3'd0, 32'hFF, "R2 size0 write");
        access(1'b1, 8'h04, 3'd7, 32'hFFFF, "R2 size7 write");
        access(1'b0, 8'h3C, 3'd4, 0, "R2 state kept");
        // R3 device-specific region
        access(1'b0, 8'h40, 3'd4, 0, "R3 read 0x40");
        access(1'b1, 8'h80, 3'd1, 32'h77, "R3 write 0x80");
        access(1'b1, 8'hFC, 3'd4, 32'h1234, "R3 write 0xFC");
        // R5 writable bytes
        access(1'b1, 8'h3C, 3'd1, 32'hAB55, "R5 int line");
        access(1'b1, 8'h0C, 3'd1, 32'h20, "R5 cache line");
        access(1'b1, 8'h0D, 3'd1, 32'hC4, "R5 latency");
        access(1'b0, 8'h0C, 3'd4, 0, "R5 readback");
        access(1'b0, 8'h3C, 3'd4, 0, "R5 readback");
        // R6 ignored and rejected byte writes
        access(1'b1, 8'h3D, 3'd1, 32'h99, "R6 pin ignored");
        access(1'b1, 8'h3E, 3'd1, 32'h99, "R6 mingnt ignored");
        access(1'b1, 8'h3F, 3'd1, 32'h99, "R6 maxlat ignored");
        access(1'b1, 8'h0B, 3'd1, 32'h99, "R6 class ignored");
        access(1'b1, 8'h08, 3'd1, 32'h99, "R6 rev ignored");
        access(1'b0, 8'h3C, 3'd4, 0, "R6 readback");
        access(1'b0, 8'h08, 3'd4, 0, "R6 readback");
        access(1'b1, 8'h00, 3'd1, 32'h11, "R6 vendor reject");
        access(1'b1, 8'h04, 3'd1, 32'h11, "R6 cmd byte reject");
        access(1'b1, 8'h10, 3'd1, 32'h11, "R6 bar byte reject");
        access(1'b0, 8'h00, 3'd4, 0, "R6 readback");
        // R7 command word
        access(1'b1, 8'h04, 3'd2, 32'h0007, "R7 cmd half");
        access(1'b0, 8'h04, 3'd4, 0, "R7 readback");
        access(1'b1, 8'h04, 3'd4, 32'hFFFF_0146, "R7 cmd word");
        access(1'b0, 8'h04, 3'd4, 0, "R7 status kept");
        access(1'b1, 8'h06, 3'd2, 32'h0000, "R7 status half reject");
        access(1'b1, 8'h10, 3'd2, 32'h1000, "R7 bar half reject");
        access(1'b1, 8'h00, 3'd4, 32'hDEAD_BEEF, "R7 id word ignored");
        access(1'b1, 8'h3C, 3'd4, 32'h0000_0077, "R7 intline word ignored");
        access(1'b0, 8'h00, 3'd4, 0, "R7 readback");
        access(1'b0, 8'h3C, 3'd4, 0, "R7 readback");
        // R8 size probes on memory, I/O, prefetch-typed and unimplemented BARs
        for (int i = 0; i < NB; i++) access(1'b1, 8'('h10 + 4 * i), 3'd4, 32'hFFFF_FFFF, "R8 probe");
        for (int i = 0; i < NB; i++) access(1'b0, 8'('h10 + 4 * i), 3'd4, 0, "R8 probe readback");
        // R9 normal BAR writes, type bits protected
        access(1'b1, 8'h10, 3'd4, 32'h1234_5678, "R9 mem bar");
        access(1'b1, 8'h14, 3'd4, 32'hABCD_0002, "R9 io bar");
        access(1'b1, 8'h1C, 3'd4, 32'h0000_0007, "R9 mem typed zero addr");
        access(1'b1, 8'h18, 3'd4, 32'hFFFF_FFFF, "R11 probe keeps valid");
        access(1'b1, 8'h18, 3'd4, 32'h8000_0000, "R9 mem bar2");
        access(1'b1, 8'h18, 3'd4, 32'hFFFF_FFFF, "R11 probe keeps valid");
        for (int i = 0; i < NB; i++) access(1'b0, 8'('h10 + 4 * i), 3'd4, 0, "R9 readback");
        access(1'b1, 8'h10, 3'd4, 32'h0000_000F, "R11 valid drops");
        // R10 expansion ROM base
        access(1'b1, 8'h30, 3'd4, 32'hFFFF_FFFE, "R10 rom probe");
        access(1'b0, 8'h30, 3'd4, 0, "R10 rom readback");
        access(1'b1, 8'h30, 3'd4, 32'h000C_0001, "R10 rom store");
        access(1'b0, 8'h30, 3'd4, 0, "R10 rom readback");
        access(1'b1, 8'h30, 3'd4, 32'hFFFF_FFFF, "R10 rom ones");
        access(1'b0, 8'h30, 3'd4, 0, "R10 rom readback");
        // R1 reset in the middle of the run
        do_reset();
        read_all("R1 reset again");
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule